// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block contains three independent 32-bit timer channels that share one run-control register. Each channel counts down by one on each tick from its chosen source. When it has to step below zero it loads its reload value again, latches an underflow flag and, when enabled, drives its own level interrupt. The tick source for each channel is one of three kinds: the peripheral clock-enable strobe divided by a power of four, a slow real-time tick, or an external tick pulse.

Software reaches every register through a simple word-wide register bus. A write takes effect at the clock edge of the write cycle. Reads are combinational from the addressed register. A channel's prescaler restarts its phase whenever the channel is started or its count is written, so the first tick after either event arrives a full divide period later.

Top module: `tmu3_timer`

## Requirements
- R1: After reset, every count and reload register reads 0xFFFFFFFF, every control register and the run register read 0, and all interrupts are low.
- R2: Byte addresses are decoded on bits [5:2]. The run register is at 0x00. Channel k has its control register at 0x04+12k, its reload register at 0x08+12k and its count register at 0x0C+12k. Unmapped words read 0. Control reads back select in [2:0], interrupt enable in bit 5 and underflow flag in bit 8, with every other bit 0.
- R3: Run bit k (bits 0..2) gates channel k. Writing a 1 over a 0 starts the channel with its prescaler phase cleared. Writing a 0 stops the channel, and its count then holds.
- R4: Select 0..5 ticks once every 4, 16, 64, 256, 1024 or 4096 cycles in which the peripheral enable is high. Select 6 ticks on each cycle with the real-time tick high. Select 7 ticks on each cycle with the external tick high.
- R5: Each tick decrements the count. From a loaded value N, the tick numbered N+1 finds the count at 0 and loads the reload value instead.
- R6: The underflow flag is set by underflow and stays set. A control write can clear it by writing 0 to bit 8, but can never set it. If an underflow and a control write fall in the same cycle, the flag ends up set.
- R7: Interrupt k is high exactly while channel k's flag and enable are both 1. It goes high in the cycle after an enable write over a set flag, and goes low in the cycle after either bit is cleared.
- R8: Writing the count register loads the count and clears the prescaler phase, even while the channel is running. No tick is taken in the cycle of that write.
- R9: Changing the select of a running channel keeps its count, and the new source governs the next tick.
- R10: For a divide of D with the peripheral enable held high, the first tick lands on the D-th clock edge after the start or count write. Writing the run register with a bit that is already 1 leaves that channel's phase alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_en | input | 1 | Peripheral clock-enable strobe feeding the dividers |
| rtc_tick | input | 1 | Slow real-time tick, one cycle wide |
| ext_tick | input | 1 | External tick, one cycle wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-channel level interrupt |

## Verification
Every effect of a write appears on bus_rdata and irq right after the rising edge that closes the write cycle. A divided tick changes the count on the D-th enabled edge after the phase restarts. Real-time and external ticks act on the edge of the cycle in which they are high. The bench drives each cycle's inputs on the falling edge and advances its own model at the rising edge. It then compares irq and the read data for the address being driven at the next falling edge, so every result is checked in the first cycle it is due. Directed checks also sample the count on the 11th and 12th edge after a start, to pin down the exact underflow edge.

// File: rtl/tmu3_pkg.sv
package tmu3_pkg;

  localparam int PRE_W       = 12;
  localparam int CTL_IE_BIT  = 5;
  localparam int CTL_UF_BIT  = 8;
  localparam logic [2:0] SEL_RTC = 3'd6;
  localparam logic [2:0] SEL_EXT = 3'd7;

  // Terminal prescaler value for selects 0..5: divide of 4^(sel+1), minus one.
  function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] sel);
    logic [PRE_W+1:0] d;
    d = (PRE_W+2)'(4) << (2 * sel);
    return PRE_W'(d - 1'b1);
  endfunction

endpackage

// File: rtl/tmu3_prescale.sv
module tmu3_prescale
  import tmu3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pclk_en,
  input  logic       rtc_tick,
  input  logic       ext_tick,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic             div_src;

  assign div_src = (sel != SEL_RTC) && (sel != SEL_EXT);

  always_comb begin
    pre_n = pre_q;
    tick  = 1'b0;
    if (restart) begin
      pre_n = '0;
    end else if (run && div_src) begin
      if (pclk_en) begin
        if (pre_q >= pre_limit(sel)) begin
          pre_n = '0;
          tick  = 1'b1;
        end else begin
          pre_n = pre_q + 1'b1;
        end
      end
    end else if (run) begin
      tick = (sel == SEL_EXT) ? ext_tick : rtc_tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end

endmodule

// File: rtl/tmu3_channel.sv
module tmu3_channel
  import tmu3_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_ctrl,
  input  logic             wr_rel,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rel,
  output logic [2:0]       sel,
  output logic             ie,
  output logic             flag,
  output logic             uf,
  output logic             irq
);

  logic [CNT_W-1:0] cnt_n, rel_n;
  logic [2:0]       sel_n;
  logic             ie_n, flag_n;

  assign uf = tick && !wr_cnt && (cnt == '0);

  always_comb begin
    cnt_n  = cnt;
    rel_n  = rel;
    sel_n  = sel;
    ie_n   = ie;
    flag_n = flag;
    if (wr_cnt)
      cnt_n = wdata;
    else if (tick)
      cnt_n = (cnt == '0) ? rel : cnt - 1'b1;
    if (wr_rel)
      rel_n = wdata;
    if (wr_ctrl) begin
      sel_n  = wdata[2:0];
      ie_n   = wdata[CTL_IE_BIT];
      flag_n = flag & wdata[CTL_UF_BIT];
    end
    flag_n = flag_n | uf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '1;
      rel  <= '1;
      sel  <= '0;
      ie   <= 1'b0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      rel  <= rel_n;
      sel  <= sel_n;
      ie   <= ie_n;
      flag <= flag_n;
    end
  end

  assign irq = flag & ie;

endmodule

// File: rtl/tmu3_timer.sv
module tmu3_timer
  import tmu3_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_en,
  input  logic              rtc_tick,
  input  logic              ext_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int REGS   = 3;

  logic [WORD_W-1:0]           word;
  logic [NCH-1:0]              run_q, run_n;
  logic [NCH-1:0]              wr_run, start_rise;
  logic [NCH-1:0]              wr_ctrl, wr_rel, wr_cnt, restart;
  logic [NCH-1:0]              tick, uf, flag, ie;
  logic [NCH-1:0][CNT_W-1:0]   cnt, rel;
  logic [NCH-1:0][2:0]         sel;

  assign word = bus_addr[ADDR_W-1:2];

  always_comb begin
    run_n = run_q;
    if (bus_wr && word == '0)
      run_n = bus_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_n;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(1 + REGS * k);
    localparam logic [WORD_W-1:0] W_REL  = WORD_W'(2 + REGS * k);
    localparam logic [WORD_W-1:0] W_CNT  = WORD_W'(3 + REGS * k);

    assign wr_run[k]     = bus_wr && (word == '0);
    assign start_rise[k] = wr_run[k] && bus_wdata[k] && !run_q[k];
    assign wr_ctrl[k]    = bus_wr && (word == W_CTRL);
    assign wr_rel[k]     = bus_wr && (word == W_REL);
    assign wr_cnt[k]     = bus_wr && (word == W_CNT);
    assign restart[k]    = start_rise[k] || wr_cnt[k];

    tmu3_prescale u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .pclk_en  (pclk_en),
      .rtc_tick (rtc_tick),
      .ext_tick (ext_tick),
      .run      (run_q[k]),
      .restart  (restart[k]),
      .sel      (sel[k]),
      .tick     (tick[k])
    );

    tmu3_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick[k]),
      .wr_ctrl (wr_ctrl[k]),
      .wr_rel  (wr_rel[k]),
      .wr_cnt  (wr_cnt[k]),
      .wdata   (bus_wdata),
      .cnt     (cnt[k]),
      .rel     (rel[k]),
      .sel     (sel[k]),
      .ie      (ie[k]),
      .flag    (flag[k]),
      .uf      (uf[k]),
      .irq     (irq[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (word == '0)
      bus_rdata[NCH-1:0] = run_q;
    for (int k = 0; k < NCH; k++) begin
      if (word == WORD_W'(1 + REGS * k)) begin
        bus_rdata[2:0]        = sel[k];
        bus_rdata[CTL_IE_BIT] = ie[k];
        bus_rdata[CTL_UF_BIT] = flag[k];
      end
      if (word == WORD_W'(2 + REGS * k))
        bus_rdata = rel[k];
      if (word == WORD_W'(3 + REGS * k))
        bus_rdata = cnt[k];
    end
  end

endmodule

// File: rtl/tmu3_checker.sv
module tmu3_checker #(
  parameter int NCH   = 3,
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCH-1:0]           run_q,
  input logic [NCH-1:0]           tick,
  input logic [NCH-1:0]           uf,
  input logic [NCH-1:0]           flag,
  input logic [NCH-1:0]           wr_ctrl,
  input logic [NCH-1:0]           wr_cnt,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][CNT_W-1:0] rel,
  input logic [NCH-1:0]           irq
);

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[k] |-> run_q[k]);

    assert_frozen_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[k] && !wr_cnt[k]) |=> (cnt[k] == $past(cnt[k])));

    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[k] && !wr_cnt[k] && cnt[k] != '0) |=> (cnt[k] == $past(cnt[k]) - 1'b1));

    assert_reload_on_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      uf[k] |=> (cnt[k] == $past(rel[k])));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[k] && !wr_ctrl[k]) |=> flag[k]);

    assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[k] && !uf[k]) |=> !flag[k]);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[k]) |-> $past(uf[k] || wr_ctrl[k]));
  end

endmodule

bind tmu3_timer tmu3_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_tmu3_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_q   (run_q),
  .tick    (tick),
  .uf      (uf),
  .flag    (flag),
  .wr_ctrl (wr_ctrl),
  .wr_cnt  (wr_cnt),
  .cnt     (cnt),
  .rel     (rel),
  .irq     (irq)
);

// File: tb/tb_tmu3_timer.sv
`timescale 1ns/1ps
module tb_tmu3_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pclk_en, rtc_tick, ext_tick, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  irq;

  always #2 clk = ~clk;

  tmu3_timer dut (
    .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .rtc_tick(rtc_tick),
    .ext_tick(ext_tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [31:0] m_cnt[3], m_rel[3];
  bit [2:0]  m_sel[3];
  bit        m_ie[3], m_flag[3], m_run[3];
  int        m_pre[3];

  function automatic bit [31:0] m_read(input bit [5:0] a);
    int w = a[5:2];
    if (w == 0) return {29'd0, m_run[2], m_run[1], m_run[0]};
    for (int k = 0; k < 3; k++) begin
      if (w == 1 + 3*k) return {23'd0, m_flag[k], 2'd0, m_ie[k], 2'd0, m_sel[k]};
      if (w == 2 + 3*k) return m_rel[k];
      if (w == 3 + 3*k) return m_cnt[k];
    end
    return 32'd0;
  endfunction

  task automatic m_step(input bit w, input bit [5:0] a, input bit [31:0] d,
                        input bit pe, input bit rt, input bit ex);
    int wd = a[5:2];
    for (int k = 0; k < 3; k++) begin
      bit rs, tk, u;
      rs = w && ((wd == 0 && d[k] && !m_run[k]) || wd == 3 + 3*k);
      tk = 0;
      if (rs) m_pre[k] = 0;
      else if (m_run[k] && m_sel[k] < 6) begin
        if (pe) begin
          if (m_pre[k] >= (4 << (2*m_sel[k])) - 1) begin tk = 1; m_pre[k] = 0; end
          else m_pre[k]++;
        end
      end else if (m_run[k]) tk = (m_sel[k] == 7) ? ex : rt;
      u = tk && !(w && wd == 3 + 3*k) && m_cnt[k] == 0;
      if (w && wd == 3 + 3*k) m_cnt[k] = d;
      else if (tk) m_cnt[k] = (m_cnt[k] == 0) ? m_rel[k] : m_cnt[k] - 1;
      if (w && wd == 1 + 3*k) begin
        m_sel[k]  = d[2:0];
        m_ie[k]   = d[5];
        m_flag[k] = m_flag[k] & d[8];
      end
      if (u) m_flag[k] = 1;
      if (w && wd == 2 + 3*k) m_rel[k] = d;
    end
    if (w && wd == 0) for (int k = 0; k < 3; k++) m_run[k] = d[k];
  endtask

  task automatic chk(input string req, input bit [31:0] act, input bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit [2:0] ei;
    for (int k = 0; k < 3; k++) ei[k] = m_flag[k] & m_ie[k];
    chk("R7", {29'd0, irq}, {29'd0, ei});
    chk(cur_req, bus_rdata, m_read(bus_addr));
  endtask

  task automatic step(input bit w, input bit [5:0] a, input bit [31:0] d,
                      input bit pe = 1, input bit rt = 0, input bit ex = 0);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    pclk_en = pe; rtc_tick = rt; ext_tick = ex;
    @(posedge clk);
    m_step(w, a, d, pe, rt, ex);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input bit [5:0] a, input bit pe = 1,
                      input bit rt = 0, input bit ex = 0);
    for (int i = 0; i < n; i++) step(0, a, 0, pe, rt, ex);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pclk_en = 0; rtc_tick = 0; ext_tick = 0;
    for (int k = 0; k < 3; k++) begin
      m_cnt[k] = '1; m_rel[k] = '1; m_sel[k] = 0;
      m_ie[k] = 0; m_flag[k] = 0; m_run[k] = 0; m_pre[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R2: reset values over the whole map, including unmapped words
    cur_req = "R1";
    for (int w = 0; w < 16; w++) idle(1, 6'(w*4), 0);
    step(0, 6'h0C, 0, 0);
    chk("R1", bus_rdata, 32'hFFFF_FFFF);

    // R5 / R10 / R7: ch0 reload 5, count 2, divide 4, interrupt enabled
    cur_req = "R5";
    step(1, 6'h08, 5);
    step(1, 6'h0C, 2);
    step(1, 6'h04, 32'h20);
    step(1, 6'h00, 1);
    idle(11, 6'h0C);
    chk("R5", bus_rdata, 0);
    chk("R10", {31'd0, irq[0]}, 0);
    idle(1, 6'h0C);
    chk("R5", bus_rdata, 5);
    chk("R7", {31'd0, irq[0]}, 1);

    // R7 / R6: enable and flag interplay
    cur_req = "R7";
    step(1, 6'h04, 32'h100);
    chk("R7", {31'd0, irq[0]}, 0);
    step(1, 6'h04, 32'h120);
    chk("R7", {31'd0, irq[0]}, 1);
    cur_req = "R6";
    step(1, 6'h04, 32'h020);
    chk("R6", bus_rdata & 32'h100, 0);
    step(1, 6'h04, 32'h120);
    chk("R6", bus_rdata & 32'h100, 0);

    // R3: stop freezes, restart refreshes phase; rewriting a 1 keeps phase
    cur_req = "R3";
    step(1, 6'h00, 0);
    idle(20, 6'h0C);
    step(1, 6'h00, 1);
    idle(3, 6'h0C);
    step(1, 6'h00, 1);
    idle(10, 6'h0C);

    // R8: count write while running
    cur_req = "R8";
    step(1, 6'h0C, 3);
    idle(3, 6'h0C);
    chk("R8", bus_rdata, 3);
    idle(1, 6'h0C);
    chk("R8", bus_rdata, 2);

    // R4: ch1 on real-time tick, ch2 on external tick
    cur_req = "R4";
    step(1, 6'h10, 32'h26);
    step(1, 6'h18, 1);
    step(1, 6'h14, 7);
    step(1, 6'h1C, 32'h27);
    step(1, 6'h24, 4);
    step(1, 6'h00, 7);
    for (int i = 0; i < 40; i++) step(0, 6'(i % 2 ? 6'h18 : 6'h24), 0, 1, (i % 5) == 0, (i % 3) == 0);

    // R9: select change on a running channel
    cur_req = "R9";
    step(1, 6'h04, 32'h21);
    idle(40, 6'h0C);
    step(1, 6'h04, 32'h20);
    idle(20, 6'h0C);
    step(1, 6'h04, 32'h25);
    idle(30, 6'h0C);

    // mixed traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      bit w = ($urandom % 5) == 0;
      int wd = $urandom % 11;
      bit [31:0] d;
      if (wd == 0)            d = $urandom % 8;
      else if ((wd - 1) % 3 == 0) d = ($urandom & 32'h0000_0320) | ($urandom % 3) | (($urandom % 4 == 0) ? 32'h6 : 0);
      else                    d = $urandom % 6;
      step(w, 6'(wd * 4), d, ($urandom % 4) != 0, ($urandom % 10) == 0, ($urandom % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule